// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst Transfers

This block is an SPI slave that gives an external host read and write access to an internal register space through a simple synchronous register port. All pins are sampled in the system clock domain through a short synchronizer, so the system clock must run at least eight times faster than SCLK. SPI modes 0 and 3 are both accepted. In both modes data is sampled on rising SCLK and shifted out on falling SCLK.

A frame is bounded by chip select. While chip select is low, the host first sends a 16-bit register address, most significant bit first. It then sends a control byte that carries a block number, a direction bit and an operation-mode field. If the operation mode selects variable-length transfers, a data phase follows and lasts as long as chip select stays low. After every full data byte the address steps by one inside the selected block. Reads are fetched one byte ahead so that MISO always has its next bit ready. Any other operation mode makes the slave ignore the rest of the frame.

Top module: `spi_regport_slave`

## Requirements
- R1: A frame opens on a falling edge of chip select and closes on a rising edge. While chip select is high, SCLK activity causes no register access.
- R2: The first 16 bits sampled on rising SCLK form the address, most significant bit first. The next 8 bits form the control byte: bits [7:3] block number, bit [2] direction (1 = write, 0 = read), bits [1:0] operation mode.
- R3: In a write frame, each complete data byte from MOSI, most significant bit first, is written once to the current address and block.
- R4: In a read frame, the byte read from the register port goes out on MISO most significant bit first, changing on falling SCLK. Data byte k occupies frame bits 8k+24 to 8k+31.
- R5: The address increases by 1 after every complete data byte and wraps from 0xFFFF to 0x0000. The block number stays unchanged for the whole frame.
- R6: A read frame of N bytes issues N+1 register reads: one when the control byte completes, and one for the following address on the rising edge that ends each data byte.
- R7: An operation mode other than 00 causes no register access and no MISO drive for the rest of the frame.
- R8: If chip select rises part-way through a data byte, that partial byte causes no write, and the next frame decodes from bit 0.
- R9: SPI modes 0 and 3 (idle SCLK low or high) give the same results.
- R10: The MISO output enable is low while chip select is high, during the address and control phases, and in write frames. It is high from the first falling SCLK of a read data phase until the frame ends.
- R11: A data byte whose last rising SCLK coincides with the rise of chip select is still written.
- R12: During and after reset, with no frame in progress, the MISO output enable, the read strobe and the write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for MISO pad |
| reg_addr | output | 16 | Register address of current access |
| reg_blk | output | 5 | Block number of current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
The closing rise of chip select can reach the frame decoder in the same system cycle as the rising SCLK that completes a data byte. If that happens, the write for the byte must still be issued before the decoder returns to idle. The bench provokes this by moving SCLK high and chip select high at the same instant, so both pass through identical synchronizer stages. It then expects the last byte to appear in the write log at the stepped address. A companion case raises chip select a few bits into a byte and expects exactly the bytes that were completed before it.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } frame_phase_e;

  localparam logic [1:0] OPM_VARLEN = 2'b00;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int             W        = 3,
  parameter int             STAGES   = 2,
  parameter logic [W-1:0]   IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_rp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BLK_W-1:0]  reg_blk_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  output logic              rd_phase_o,
  output logic              sck_fall_o
);
  localparam int CTL_W    = BLK_W + 3;
  localparam int HDR_BITS = ADDR_W + CTL_W;
  localparam int HCNT_W   = $clog2(HDR_BITS);
  localparam int BIT_W    = $clog2(DATA_W);

  logic cs_prev_q, sck_prev_q;
  logic cs_fall, cs_rise, sck_rise, sck_fall;

  frame_phase_e              phase_q, phase_d;
  logic [HCNT_W-1:0]         hcnt_q, hcnt_d;
  logic [HDR_BITS-2:0]       hdr_q, hdr_d;
  logic [BIT_W-1:0]          bidx_q, bidx_d;
  logic [ADDR_W-1:0]         addr_q, addr_d;
  logic [BLK_W-1:0]          blk_q, blk_d;
  logic                      wmode_q, wmode_d;
  logic [DATA_W-2:0]         dsh_q, dsh_d;
  logic [CTL_W-1:0]          ctl_byte;

  logic                      acc_rd, acc_wr;
  logic [ADDR_W-1:0]         acc_addr;
  logic [BLK_W-1:0]          acc_blk;
  logic                      rd_q, wr_q;
  logic [ADDR_W-1:0]         raddr_q;
  logic [BLK_W-1:0]          rblk_q;
  logic [DATA_W-1:0]         wdata_q;

  assign cs_fall  =  cs_prev_q & ~cs_n_s;
  assign cs_rise  = ~cs_prev_q &  cs_n_s;
  assign sck_rise = ~sck_prev_q &  sck_s;
  assign sck_fall =  sck_prev_q & ~sck_s;
  assign ctl_byte = {hdr_q[CTL_W-2:0], mosi_s};

  always_comb begin
    phase_d  = phase_q;
    hcnt_d   = hcnt_q;
    hdr_d    = hdr_q;
    bidx_d   = bidx_q;
    addr_d   = addr_q;
    blk_d    = blk_q;
    wmode_d  = wmode_q;
    dsh_d    = dsh_q;
    acc_rd   = 1'b0;
    acc_wr   = 1'b0;
    acc_addr = addr_q;
    acc_blk  = blk_q;
    if (sck_rise) begin
      case (phase_q)
        PH_HDR: begin
          hdr_d  = {hdr_q[HDR_BITS-3:0], mosi_s};
          hcnt_d = hcnt_q + 1'b1;
          if (hcnt_q == HCNT_W'(HDR_BITS - 1)) begin
            addr_d  = hdr_q[HDR_BITS-2 -: ADDR_W];
            blk_d   = ctl_byte[CTL_W-1 -: BLK_W];
            wmode_d = ctl_byte[2];
            if (ctl_byte[1:0] == OPM_VARLEN) begin
              phase_d = PH_DATA;
              acc_rd  = ~ctl_byte[2];
            end else begin
              phase_d = PH_SKIP;
            end
            acc_addr = addr_d;
            acc_blk  = blk_d;
          end
        end
        PH_DATA: begin
          dsh_d  = {dsh_q[DATA_W-3:0], mosi_s};
          bidx_d = bidx_q + 1'b1;
          if (bidx_q == BIT_W'(DATA_W - 1)) begin
            addr_d   = addr_q + 1'b1;
            acc_wr   = wmode_q;
            acc_rd   = ~wmode_q;
            acc_addr = wmode_q ? addr_q : addr_d;
          end
        end
        default: ;
      endcase
    end
    if (cs_fall) begin
      phase_d = PH_HDR;
      hcnt_d  = '0;
      bidx_d  = '0;
    end
    if (cs_rise) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
      phase_q    <= PH_IDLE;
      hcnt_q     <= '0;
      hdr_q      <= '0;
      bidx_q     <= '0;
      addr_q     <= '0;
      blk_q      <= '0;
      wmode_q    <= 1'b0;
      dsh_q      <= '0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      raddr_q    <= '0;
      rblk_q     <= '0;
      wdata_q    <= '0;
    end else begin
      cs_prev_q  <= cs_n_s;
      sck_prev_q <= sck_s;
      phase_q    <= phase_d;
      hcnt_q     <= hcnt_d;
      hdr_q      <= hdr_d;
      bidx_q     <= bidx_d;
      addr_q     <= addr_d;
      blk_q      <= blk_d;
      wmode_q    <= wmode_d;
      dsh_q      <= dsh_d;
      rd_q       <= acc_rd;
      wr_q       <= acc_wr;
      if (acc_rd || acc_wr) begin
        raddr_q <= acc_addr;
        rblk_q  <= acc_blk;
      end
      if (acc_wr) wdata_q <= {dsh_q, mosi_s};
    end
  end

  assign reg_addr_o  = raddr_q;
  assign reg_blk_o   = rblk_q;
  assign reg_wr_o    = wr_q;
  assign reg_rd_o    = rd_q;
  assign reg_wdata_o = wdata_q;
  assign rd_phase_o  = (phase_q == PH_DATA) && !wmode_q;
  assign sck_fall_o  = sck_fall;

  // R1: nothing is accessed out of an idle decoder
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_IDLE) |-> !(reg_rd_o || reg_wr_o));
  // R7: a frame with an unsupported mode is ignored
  p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_SKIP) |-> !(reg_rd_o || reg_wr_o));
  // R5: block number frozen through the data phase
  p_blk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && $past(phase_q) == PH_DATA) |-> $stable(blk_q));
  // R3: writes only come from a write-direction data phase
  p_wr_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> ($past(wmode_q) && $past(phase_q) == PH_DATA));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_phase_i,
  input  logic              shift_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              miso_o,
  output logic              oe_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] hold_q, hold_d, sh_q, sh_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic              live_q, live_d, pend_q;

  always_comb begin
    hold_d = pend_q ? rd_data_i : hold_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    live_d = live_q;
    if (!rd_phase_i) begin
      bcnt_d = '0;
      live_d = 1'b0;
    end else if (shift_i) begin
      sh_d   = (bcnt_q == '0) ? hold_q : {sh_q[DATA_W-2:0], 1'b0};
      bcnt_d = bcnt_q + 1'b1;
      live_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      bcnt_q <= '0;
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      live_q <= live_d;
      pend_q <= rd_req_i;
    end
  end

  assign miso_o = sh_q[DATA_W-1];
  assign oe_o   = live_q;

  // R10: enable drops once the read data phase is over
  p_oe_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_phase_i |=> !oe_o);
  // R4: MISO only moves on a falling SCLK
  p_miso_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(live_q) && !$past(shift_i)) |-> $stable(miso_o));
endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave #(
  parameter int ADDR_W      = 16,
  parameter int BLK_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BLK_W-1:0]  reg_blk,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cs_s, sck_s, mosi_s;
  logic       rd_phase, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_pin_sync #(
    .W        (3),
    .STAGES   (SYNC_STAGES),
    .IDLE_VAL (3'b100)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_i ({spi_cs_n, spi_sck, spi_mosi}),
    .lvl_o ({cs_s, sck_s, mosi_s})
  );

  spi_frame_ctl #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W),
    .DATA_W (DATA_W)
  ) i_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_n_s      (cs_s),
    .sck_s       (sck_s),
    .mosi_s      (mosi_s),
    .reg_addr_o  (reg_addr),
    .reg_blk_o   (reg_blk),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rd_o    (reg_rd),
    .rd_phase_o  (rd_phase),
    .sck_fall_o  (sck_fall)
  );

  spi_tx_shift #(
    .DATA_W (DATA_W)
  ) i_tx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_phase_i (rd_phase),
    .shift_i    (sck_fall),
    .rd_req_i   (reg_rd),
    .rd_data_i  (reg_rdata),
    .miso_o     (spi_miso),
    .oe_o       (spi_miso_oe)
  );
endmodule

// File: tb/test_spi_regport_slave.sv
module test_spi_regport_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 10;
  localparam int NV    = 8;

  typedef struct packed {
    logic        m3;
    logic [15:0] addr;
    logic [4:0]  blk;
    logic        wr;
    logic [1:0]  op;
    logic [2:0]  nb;
    logic [31:0] wd;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0010, 5'd1,  1'b1, 2'b00, 3'd2, 32'hA55A_0000},
    '{1'b1, 16'h1234, 5'd2,  1'b1, 2'b00, 3'd3, 32'h0180_FF00},
    '{1'b0, 16'h0040, 5'd3,  1'b0, 2'b00, 3'd3, 32'h0000_0000},
    '{1'b1, 16'h7FF0, 5'd0,  1'b0, 2'b00, 3'd4, 32'h0000_0000},
    '{1'b0, 16'h0005, 5'd1,  1'b0, 2'b01, 3'd2, 32'h0000_0000},
    '{1'b1, 16'hFFFF, 5'd4,  1'b1, 2'b00, 3'd2, 32'h3CC3_0000},
    '{1'b0, 16'hFFFE, 5'd31, 1'b0, 2'b00, 3'd4, 32'h0000_0000},
    '{1'b1, 16'h0100, 5'd6,  1'b1, 2'b10, 3'd2, 32'h7777_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sck, mosi;
  logic        miso, miso_oe;
  logic [15:0] reg_addr;
  logic [4:0]  reg_blk;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata, reg_rdata;

  int errs = 0;
  int checks = 0;
  int wcnt = 0;
  int rcnt = 0;
  logic [15:0] wl_a [64];
  logic [4:0]  wl_b [64];
  logic [7:0]  wl_d [64];

  always #(CLK_P/2) clk = ~clk;

  spi_regport_slave i_spi_regport_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (cs_n),
    .spi_sck     (sck),
    .spi_mosi    (mosi),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe),
    .reg_addr    (reg_addr),
    .reg_blk     (reg_blk),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rd      (reg_rd),
    .reg_rdata   (reg_rdata)
  );

  function automatic logic [7:0] fexp(input logic [15:0] a, input logic [4:0] b);
    return a[7:0] ^ a[15:8] ^ {b, 3'b000};
  endfunction

  // register-space model: read data valid in the cycle after reg_rd
  always @(negedge clk) begin
    if (reg_rd) begin
      reg_rdata <= fexp(reg_addr, reg_blk);
      rcnt <= rcnt + 1;
    end
    if (reg_wr) begin
      wl_a[wcnt % 64] <= reg_addr;
      wl_b[wcnt % 64] <= reg_blk;
      wl_d[wcnt % 64] <= reg_wdata;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit m3, input logic [15:0] a, input logic [7:0] ctl,
                      input int nbits, input logic [31:0] wd, input bit join_end,
                      output logic [31:0] rd, output bit oe_bad);
    logic [23:0] hdr;
    bit rdmode;
    hdr    = {a, ctl};
    rdmode = (ctl[2] == 1'b0) && (ctl[1:0] == 2'b00);
    rd     = '0;
    oe_bad = 1'b0;
    sck    = m3;
    cs_n   = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      logic v;
      v = (b < 24) ? hdr[23-b] : wd[31-(b-24)];
      if (m3) sck = 1'b0;
      mosi = v;
      repeat (HALF) @(negedge clk);
      if (join_end && b == nbits - 1) begin
        sck  = 1'b1;
        cs_n = 1'b1;
      end else begin
        sck = 1'b1;
        if (b >= 24) rd[31-(b-24)] = miso;
        if (miso_oe !== ((b >= 24) && rdmode)) oe_bad = 1'b1;
        repeat (HALF) @(negedge clk);
        if (!m3) sck = 1'b0;
      end
    end
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp;
    bit oe_bad;
    int w0, r0;
    cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R12: reset state
    chk(!miso_oe && !reg_rd && !reg_wr, "R12 reset outputs", {29'd0, miso_oe, reg_rd, reg_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!miso_oe && !reg_rd && !reg_wr, "R12 after reset", {29'd0, miso_oe, reg_rd, reg_wr}, 32'd0);

    // R1: clocking with chip select high does nothing
    w0 = wcnt; r0 = rcnt;
    for (int i = 0; i < 30; i++) begin
      sck = ~sck; mosi = ~mosi;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
    repeat (6) @(negedge clk);
    chk((wcnt == w0) && (rcnt == r0) && !miso_oe, "R1 idle clocking",
        32'(wcnt - w0 + rcnt - r0), 32'd0);

    // vector table: R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      bit rdf, wrf;
      t = VEC[v];
      rdf = (t.op == 2'b00) && !t.wr;
      wrf = (t.op == 2'b00) &&  t.wr;
      w0 = wcnt; r0 = rcnt;
      xfer(t.m3, t.addr, {t.blk, t.wr, t.op}, 24 + 8 * int'(t.nb), t.wd, 1'b0, rd, oe_bad);
      chk(!oe_bad, t.m3 ? "R10 R9 oe timing mode3" : "R10 oe timing mode0", {31'd0, oe_bad}, 32'd0);
      chk(!miso_oe, "R10 oe low after frame", {31'd0, miso_oe}, 32'd0);
      if (rdf) begin
        exp = '0;
        for (int k = 0; k < int'(t.nb); k++) exp[31-8*k -: 8] = fexp(t.addr + 16'(k), t.blk);
        chk(rd == exp, t.m3 ? "R4 R5 R9 burst read mode3" : "R4 R5 burst read mode0", rd, exp);
        chk(rcnt - r0 == int'(t.nb) + 1, "R6 prefetch count", 32'(rcnt - r0), 32'(t.nb + 1));
        chk(wcnt == w0, "R3 no write in read", 32'(wcnt - w0), 32'd0);
      end else if (wrf) begin
        chk(wcnt - w0 == int'(t.nb), "R3 write count", 32'(wcnt - w0), 32'(t.nb));
        chk(rcnt == r0, "R3 no read in write", 32'(rcnt - r0), 32'd0);
        for (int k = 0; k < int'(t.nb); k++) begin
          int ix;
          ix = (w0 + k) % 64;
          chk({wl_b[ix], wl_a[ix]} == {t.blk, t.addr + 16'(k)}, "R2 R5 write address",
              {11'd0, wl_b[ix], wl_a[ix]}, {11'd0, t.blk, t.addr + 16'(k)});
          chk(wl_d[ix] == t.wd[31-8*k -: 8], t.m3 ? "R3 R9 write data mode3" : "R3 write data mode0",
              {24'd0, wl_d[ix]}, {24'd0, t.wd[31-8*k -: 8]});
        end
      end else begin
        chk((wcnt == w0) && (rcnt == r0), "R7 unsupported mode ignored",
            32'(wcnt - w0 + rcnt - r0), 32'd0);
      end
    end

    // R8: chip select rises five bits into the second byte
    w0 = wcnt;
    xfer(1'b0, 16'h0200, {5'd9, 1'b1, 2'b00}, 24 + 8 + 5, 32'h1122_3344, 1'b0, rd, oe_bad);
    chk(wcnt - w0 == 1, "R8 partial byte dropped", 32'(wcnt - w0), 32'd1);
    chk(wl_d[w0 % 64] == 8'h11 && wl_a[w0 % 64] == 16'h0200, "R8 full byte kept",
        {8'd0, wl_a[w0 % 64], wl_d[w0 % 64]}, 32'h0002_0011);
    // R8: next frame decodes from bit 0
    r0 = rcnt;
    xfer(1'b1, 16'h0033, {5'd2, 1'b0, 2'b00}, 24 + 8, 32'h0, 1'b0, rd, oe_bad);
    exp = {fexp(16'h0033, 5'd2), 24'd0};
    chk(rd == exp, "R8 fresh frame after cut", rd, exp);

    // R11: last rising SCLK and chip-select release together, both modes
    for (int m = 0; m < 2; m++) begin
      w0 = wcnt;
      xfer(m[0], 16'h0400, {5'd5, 1'b1, 2'b00}, 24 + 16, 32'hBEEF_0000, 1'b1, rd, oe_bad);
      chk(wcnt - w0 == 2, "R11 coincident end write count", 32'(wcnt - w0), 32'd2);
      chk(wl_d[(w0 + 1) % 64] == 8'hEF && wl_a[(w0 + 1) % 64] == 16'h0401, "R11 coincident end data",
          {8'd0, wl_a[(w0 + 1) % 64], wl_d[(w0 + 1) % 64]}, 32'h0004_01EF);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule